// File: doc/BRIEF.md
# Multipurpose Status Pin Controller

This block manages three multipurpose pins on a power-management chip. Three configuration bits for each pin let a host choose one of three modes. In sampled-input mode the pin level is reported back to the host. In driven-output mode the host sets the pin level directly. In status mode the pin works as an open-drain, active-low indicator of a chip condition. The host reaches the configuration through a simple write port (`wr_en`, `wr_cfg`). The serial bus engine that would feed this port, and the pad cells, sit outside the block.

The status functions differ from pin to pin. Pin 0 reports charging activity. When the chemistry input marks a lead-acid battery, pin 0 instead reports that the C/x point of the charge cycle has been reached. Pin 1 reports a sticky backup-fault flag. Pins 2 and above report charging activity whatever the chemistry. The backup-fault flag is set by a fault event and cleared only by a command bit in the configuration word. That command bit acts one cycle after the write and then clears itself. When the no-host strap is high as the block leaves reset or shutdown, every pin is placed in status mode and host writes are ignored. In shutdown all pins are released and the configuration returns to its defaults. The fault flag is kept.

A small controller with four states sequences the block:
- BOOT is entered on reset and when shutdown ends. All pins are released. On the next cycle the strap picks the following state: BOOT_TO_HOST when the strap is low, BOOT_TO_NOHOST when it is high.
- HOST is the register-driven mode.
- NOHOST is the strap-forced status mode.
- SHDN: from any state, SHDN_ENTER is taken while `shdn` is high. SHDN_EXIT returns to BOOT once `shdn` is low.

Top module: `gpio_pin_ctrl`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `pad_oe`, `pad_do`, `pin_rd` and `bkup_fault` are all 0.
- R2: A pin in host mode with cfg fields en=0 and sel=0 is in input mode. Its `pad_oe` bit is 0, and its `pin_rd` bit follows `pad_in` through two register stages: a change is not visible after one rising edge and is visible after the second.
- R3: A pin in host mode with en=1 and sel=0 is driven: its `pad_oe` bit is 1 and its `pad_do` bit equals the cfg out bit. In `wr_cfg`, bit 3i is en, bit 3i+1 is out and bit 3i+2 is sel for pin i. A write takes effect on the rising edge at which `wr_en` is sampled high.
- R4: A pin with sel=1 is in status mode whatever its en and out bits hold. Its `pad_do` bit is 0 and its `pad_oe` bit is 1 exactly when its status condition is active (open-drain, active-low).
- R5: The charge condition is active when `chg_phase` is not 00. Here 00 means off, 01 precharge, 10 bulk and 11 top-off.
- R6: With `lead_acid`=1, the status condition of pin 0 is `cx_reached` instead of the charge condition. With `lead_acid`=0 it is the charge condition.
- R7: The status condition of pin 1 is `bkup_fault`. For pins 2 and above it is the charge condition, whatever `lead_acid` holds.
- R8: `bkup_fault` becomes 1 on the edge after `fault_set` is seen high, and then stays 1. Writing `wr_cfg` bit 9 (the top bit) as 1 in host mode clears it on the second rising edge after the write, not the first. Writes with bit 9 at 0 leave it unchanged.
- R9: If a fault event and a pending clear command meet on the same edge, `bkup_fault` stays 1.
- R10: If `no_host` is 1 when BOOT is left, every pin is in status mode, with `pad_do` all 0, and host writes have no effect on the pins.
- R11: One edge after `shdn` is seen high, `pad_oe` and `pin_rd` are 0. Leaving shutdown puts all pins back in input mode, while `bkup_fault` keeps its value.
- R12: A `pin_rd` bit is 0 for any pin that is not in input mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| shdn | input | 1 | Shutdown request |
| no_host | input | 1 | Strap that forces status mode when no host is fitted |
| wr_en | input | 1 | Configuration write strobe |
| wr_cfg | input | 10 | Configuration word: three bits per pin, plus the fault-clear command in the top bit |
| fault_set | input | 1 | Backup-fault event |
| chg_phase | input | 2 | Charge phase (00 off, 01 pre, 10 bulk, 11 top-off) |
| cx_reached | input | 1 | C/x point of the charge cycle reached |
| lead_acid | input | 1 | Chemistry is lead-acid |
| pad_in | input | 3 | Pin levels from the pads |
| pad_oe | output | 3 | Per-pin output enable |
| pad_do | output | 3 | Per-pin output data |
| pin_rd | output | 3 | Synchronised input levels of input-mode pins |
| bkup_fault | output | 1 | Sticky backup-fault flag |

## Verification
The pins are tried in each mode with patterns that tell the modes apart. A `pad_in` value held while a pin drives shows that reads are masked. Setting en and out beneath sel shows that status mode takes priority. Each nonzero `chg_phase`, compared with 00, shows the charge decode. Flipping `lead_acid` while pins 0 and 2 are both in status mode shows that only pin 0 switches to C/x. The fault flag is checked edge by edge through set, non-clearing writes, a delayed clear and a set that collides with a clear. The shutdown and strap sequences show which state survives and that writes are blocked.

// File: rtl/gpio_pin_pkg.sv
package gpio_pin_pkg;

    typedef enum logic [1:0] {
        ST_BOOT   = 2'd0,
        ST_HOST   = 2'd1,
        ST_NOHOST = 2'd2,
        ST_SHDN   = 2'd3
    } ctl_state_e;

    typedef enum logic [1:0] {
        PM_OFF    = 2'd0,
        PM_INPUT  = 2'd1,
        PM_DRIVE  = 2'd2,
        PM_STATUS = 2'd3
    } pin_mode_e;

    localparam int unsigned FIELD_W = 3;
    localparam int unsigned F_EN    = 0;
    localparam int unsigned F_OUT   = 1;
    localparam int unsigned F_SEL   = 2;

endpackage

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs
    import gpio_pin_pkg::*;
#(
    parameter int unsigned NPINS = 3,
    localparam int unsigned CW   = NPINS * FIELD_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             wr_accept,
    input  logic [CW-1:0]    wr_data,
    output logic [NPINS-1:0] en_q,
    output logic [NPINS-1:0] out_q,
    output logic [NPINS-1:0] sel_q,
    output logic             clr_pulse
);
    localparam int unsigned FR_BIT = CW - 1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q      <= '0;
            out_q     <= '0;
            sel_q     <= '0;
            clr_pulse <= 1'b0;
        end else if (clear) begin
            en_q      <= '0;
            out_q     <= '0;
            sel_q     <= '0;
            clr_pulse <= 1'b0;
        end else begin
            clr_pulse <= wr_accept && wr_data[FR_BIT];
            if (wr_accept) begin
                for (int i = 0; i < NPINS; i++) begin
                    en_q[i]  <= wr_data[i*FIELD_W + F_EN];
                    out_q[i] <= wr_data[i*FIELD_W + F_OUT];
                    sel_q[i] <= wr_data[i*FIELD_W + F_SEL];
                end
            end
        end
    end

endmodule

// File: rtl/gpio_fault_latch.sv
module gpio_fault_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic fault_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   fault_q <= 1'b0;
        else if (set) fault_q <= 1'b1;
        else if (clr) fault_q <= 1'b0;
    end
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int unsigned NPINS  = 3,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] d,
    output logic [NPINS-1:0] q
);
    for (genvar p = 0; p < NPINS; p++) begin : g_pin
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '0;
            else        chain <= {chain[STAGES-2:0], d[p]};
        end
        assign q[p] = chain[STAGES-1];
    end
endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux
    import gpio_pin_pkg::*;
#(
    parameter int unsigned NPINS = 3
) (
    input  pin_mode_e [NPINS-1:0] mode,
    input  logic [NPINS-1:0]      out_bit,
    input  logic [NPINS-1:0]      stat_act,
    input  logic [NPINS-1:0]      in_sync,
    output logic [NPINS-1:0]      oe,
    output logic [NPINS-1:0]      dout,
    output logic [NPINS-1:0]      rd
);
    for (genvar p = 0; p < NPINS; p++) begin : g_pin
        always_comb begin
            oe[p]   = 1'b0;
            dout[p] = 1'b0;
            rd[p]   = 1'b0;
            unique case (mode[p])
                PM_OFF:    ;
                PM_INPUT:  rd[p] = in_sync[p];
                PM_DRIVE: begin
                    oe[p]   = 1'b1;
                    dout[p] = out_bit[p];
                end
                PM_STATUS: oe[p] = stat_act[p];
                default:   ;
            endcase
        end
    end
endmodule

// File: rtl/gpio_pin_ctrl.sv
module gpio_pin_ctrl
    import gpio_pin_pkg::*;
#(
    parameter int unsigned NPINS = 3,
    localparam int unsigned CW   = NPINS * FIELD_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shdn,
    input  logic             no_host,
    input  logic             wr_en,
    input  logic [CW-1:0]    wr_cfg,
    input  logic             fault_set,
    input  logic [1:0]       chg_phase,
    input  logic             cx_reached,
    input  logic             lead_acid,
    input  logic [NPINS-1:0] pad_in,
    output logic [NPINS-1:0] pad_oe,
    output logic [NPINS-1:0] pad_do,
    output logic [NPINS-1:0] pin_rd,
    output logic             bkup_fault
);
    ctl_state_e           state_q;
    logic [NPINS-1:0]     en_q, out_q, sel_q, in_sync, stat_act;
    logic                 clr_pulse, fault_q, chg_act, wr_accept, cfg_clear;
    pin_mode_e [NPINS-1:0] mode;

    // state register with its transitions
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_BOOT;
        end else if (shdn) begin
            state_q <= ST_SHDN;                              // SHDN_ENTER
        end else begin
            unique case (state_q)
                ST_BOOT:   state_q <= no_host ? ST_NOHOST : ST_HOST;
                ST_HOST:   state_q <= ST_HOST;
                ST_NOHOST: state_q <= ST_NOHOST;
                ST_SHDN:   state_q <= ST_BOOT;               // SHDN_EXIT
                default:   state_q <= ST_BOOT;
            endcase
        end
    end

    // per-state pin mode selection
    always_comb begin
        for (int i = 0; i < NPINS; i++) begin
            unique case (state_q)
                ST_HOST:   mode[i] = sel_q[i] ? PM_STATUS :
                                     (en_q[i] ? PM_DRIVE : PM_INPUT);
                ST_NOHOST: mode[i] = PM_STATUS;
                ST_BOOT,
                ST_SHDN:   mode[i] = PM_OFF;
                default:   mode[i] = PM_OFF;
            endcase
        end
    end

    assign wr_accept = wr_en && !shdn && (state_q == ST_HOST);
    assign cfg_clear = (state_q == ST_SHDN);
    assign chg_act   = (chg_phase != 2'b00);

    for (genvar p = 0; p < NPINS; p++) begin : g_stat
        if (p == 0) begin : g_charge
            assign stat_act[p] = lead_acid ? cx_reached : chg_act;
        end else if (p == 1) begin : g_fault
            assign stat_act[p] = fault_q;
        end else begin : g_plain
            assign stat_act[p] = chg_act;
        end
    end

    gpio_cfg_regs #(.NPINS(NPINS)) u_regs (
        .clk(clk), .rst_n(rst_n), .clear(cfg_clear), .wr_accept(wr_accept),
        .wr_data(wr_cfg), .en_q(en_q), .out_q(out_q), .sel_q(sel_q),
        .clr_pulse(clr_pulse)
    );

    gpio_fault_latch u_fault (
        .clk(clk), .rst_n(rst_n), .set(fault_set), .clr(clr_pulse),
        .fault_q(fault_q)
    );

    gpio_in_sync #(.NPINS(NPINS), .STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(pad_in), .q(in_sync)
    );

    gpio_pin_mux #(.NPINS(NPINS)) u_mux (
        .mode(mode), .out_bit(out_q), .stat_act(stat_act), .in_sync(in_sync),
        .oe(pad_oe), .dout(pad_do), .rd(pin_rd)
    );

    assign bkup_fault = fault_q;

endmodule

// File: rtl/gpio_pin_ctrl_chk.sv
module gpio_pin_ctrl_chk
    import gpio_pin_pkg::*;
#(
    parameter int unsigned NPINS = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             shdn,
    input logic             fault_set,
    input logic             clr_pulse,
    input ctl_state_e       state_q,
    input logic [NPINS-1:0] pad_oe,
    input logic [NPINS-1:0] pad_do,
    input logic [NPINS-1:0] pin_rd,
    input logic             bkup_fault
);
    AST_SHDN_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        shdn |=> (pad_oe == '0 && pin_rd == '0)); // R11

    AST_FAULT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        fault_set |=> bkup_fault); // R9

    AST_FAULT_ONLY_CMD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bkup_fault) |-> $past(clr_pulse)); // R8

    AST_NOHOST_OPEN_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_NOHOST) |-> (pad_do == '0)); // R10

    AST_RD_NOT_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_rd & pad_oe) == '0); // R12
endmodule

bind gpio_pin_ctrl gpio_pin_ctrl_chk #(.NPINS(NPINS)) u_chk (
    .clk(clk), .rst_n(rst_n), .shdn(shdn), .fault_set(fault_set),
    .clr_pulse(clr_pulse), .state_q(state_q), .pad_oe(pad_oe),
    .pad_do(pad_do), .pin_rd(pin_rd), .bkup_fault(bkup_fault)
);

// File: tb/gpio_pin_ctrl_test.sv
`timescale 1ns/1ps
module gpio_pin_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n, shdn, no_host, wr_en, fault_set, cx_reached, lead_acid;
    logic [9:0] wr_cfg;
    logic [1:0] chg_phase;
    logic [2:0] pad_in, pad_oe, pad_do, pin_rd;
    logic       bkup_fault;
    int         checks = 0;
    int         errors = 0;
    bit         done = 1'b0;

    always #4 clk = ~clk;  // 125 MHz

    gpio_pin_ctrl uut (
        .clk(clk), .rst_n(rst_n), .shdn(shdn), .no_host(no_host),
        .wr_en(wr_en), .wr_cfg(wr_cfg), .fault_set(fault_set),
        .chg_phase(chg_phase), .cx_reached(cx_reached), .lead_acid(lead_acid),
        .pad_in(pad_in), .pad_oe(pad_oe), .pad_do(pad_do), .pin_rd(pin_rd),
        .bkup_fault(bkup_fault)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [9:0] mk(input logic [2:0] en, input logic [2:0] out,
                                      input logic [2:0] sel, input logic fr);
        logic [9:0] w;
        for (int i = 0; i < 3; i++) begin
            w[3*i] = en[i]; w[3*i+1] = out[i]; w[3*i+2] = sel[i];
        end
        w[9] = fr;
        return w;
    endfunction

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic write(input logic [9:0] w);
        wr_cfg = w; wr_en = 1'b1;
        cyc(1);
        wr_en = 1'b0; wr_cfg = '0;
    endtask

    task automatic t_reset();
        rst_n = 0; shdn = 0; no_host = 0; wr_en = 0; wr_cfg = '0; fault_set = 0;
        chg_phase = 2'b00; cx_reached = 0; lead_acid = 0; pad_in = 3'b000;
        cyc(3);
        chk("R1 oe", pad_oe, 0); chk("R1 do", pad_do, 0);
        chk("R1 rd", pin_rd, 0); chk("R1 fault", bkup_fault, 0);
        rst_n = 1;
        pad_in = 3'b111;
        cyc(1);
        chk("R1 boot oe", pad_oe, 0); chk("R1 boot rd", pin_rd, 0);
        cyc(1);
        pad_in = 3'b000;
        cyc(2);
    endtask

    task automatic t_input();
        pad_in = 3'b101;
        cyc(1);
        chk("R2 one edge", pin_rd, 3'b000);
        cyc(1);
        chk("R2 two edges", pin_rd, 3'b101);
        chk("R2 oe", pad_oe, 3'b000);
    endtask

    task automatic t_drive();
        write(mk(3'b111, 3'b010, 3'b000, 0));
        chk("R3 oe", pad_oe, 3'b111); chk("R3 do", pad_do, 3'b010);
        chk("R12 rd masked", pin_rd, 3'b000);
        write(mk(3'b001, 3'b001, 3'b000, 0));
        chk("R3 mixed oe", pad_oe, 3'b001); chk("R2 mixed rd", pin_rd, 3'b100);
    endtask

    task automatic t_status();
        write(mk(3'b101, 3'b101, 3'b101, 0));
        chg_phase = 2'b00; #1;
        chk("R5 off", pad_oe, 3'b000); chk("R12 status rd", pin_rd, 3'b000);
        for (int ph = 1; ph < 4; ph++) begin
            chg_phase = ph[1:0]; #1;
            chk("R5 active oe", pad_oe, 3'b101); chk("R4 od low", pad_do, 3'b000);
        end
        lead_acid = 1; cx_reached = 0; #1;
        chk("R6 cx low", pad_oe, 3'b100);
        cx_reached = 1; chg_phase = 2'b00; #1;
        chk("R7 pin2 plain", pad_oe, 3'b001);
        lead_acid = 0; cx_reached = 0; cyc(1);
    endtask

    task automatic t_fault();
        write(mk(3'b010, 3'b010, 3'b010, 0));
        chk("R4 no fault", pad_oe[1], 0); chk("R4 do", pad_do[1], 0);
        fault_set = 1; cyc(1); fault_set = 0;
        chk("R8 set", bkup_fault, 1); chk("R4 fault oe", pad_oe[1], 1);
        write(mk(3'b010, 3'b010, 3'b010, 0));
        cyc(2);
        chk("R8 sticky", bkup_fault, 1);
        write(mk(3'b010, 3'b010, 3'b010, 1));
        chk("R8 not yet", bkup_fault, 1);
        cyc(1);
        chk("R8 cleared", bkup_fault, 0); chk("R4 released", pad_oe[1], 0);
        fault_set = 1; cyc(1); fault_set = 0;
        write(mk(3'b010, 3'b010, 3'b010, 1));
        fault_set = 1; cyc(1); fault_set = 0;
        chk("R9 set wins", bkup_fault, 1);
        cyc(1);
        chk("R9 still set", bkup_fault, 1);
    endtask

    task automatic t_shutdown();
        write(mk(3'b111, 3'b111, 3'b000, 0));
        pad_in = 3'b111;
        shdn = 1; cyc(1);
        chk("R11 oe", pad_oe, 0); chk("R11 rd", pin_rd, 0);
        chk("R11 fault kept", bkup_fault, 1);
        write(mk(3'b111, 3'b111, 3'b000, 0));
        shdn = 0; cyc(2);
        chk("R11 default input", pad_oe, 3'b000);
        chk("R11 rd after", pin_rd, 3'b111);
        chk("R11 fault after", bkup_fault, 1);
    endtask

    task automatic t_strap();
        no_host = 1; chg_phase = 2'b01;
        shdn = 1; cyc(1); shdn = 0; cyc(2);
        chk("R10 status", pad_oe, 3'b111); chk("R10 do", pad_do, 3'b000);
        chk("R10 rd", pin_rd, 3'b000);
        write(mk(3'b111, 3'b111, 3'b000, 1));
        cyc(1);
        chk("R10 write ignored", pad_oe, 3'b111);
        chk("R10 fault kept", bkup_fault, 1);
        chg_phase = 2'b00; #1;
        chk("R10 follows", pad_oe, 3'b010);
        no_host = 0; shdn = 1; cyc(1); shdn = 0; cyc(2);
    endtask

    initial begin
        t_reset();
        t_input();
        t_drive();
        t_status();
        t_fault();
        t_shutdown();
        t_strap();
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule